// File: doc/BRIEF.md
# Buffered Page Write Sequencer

This block copies a run of bytes from a streaming source into a paged serial flash that has an on-chip SRAM page buffer. The page size does not have to be a power of two. The caller supplies a starting byte address, a byte count and a verify enable, then pulses start. The block converts the byte address into a page index and an in-page offset by repeated subtraction. It then cuts the range into chunks that never cross a page end.

For each chunk the sequencer runs up to three device commands, and it polls the device status after every one of them:

- **Fill.** Used only when the chunk covers less than a full page. It copies the flash page into the device buffer, so the program step rewrites the bytes outside the chunk unchanged.
- **Program.** It sends the chunk bytes through the buffer into the page.
- **Compare.** Used only when verify is enabled. It checks the buffer against the flash page.

If a compare reports a difference, the run stops at once. The block raises an error pulse, sets a sticky mismatch flag and records the failing page. Bytes reach the flash over a byte-level SPI handshake. A separate shifter below this block does the serial work. The block keeps chip select active across each whole command frame, including the program data.

Top module: `page_write_seq`

## Requirements
- R1: While reset is applied, and after it is released, busy, done, error, mismatch, spi_sel, spi_req and din_ready are all 0.
- R2: A start with byte_count = 0 produces a done pulse in the cycle after start is sampled. It produces no chip-select activity and no busy.
- R3: The first chunk length is min(byte_count, PAGE_SIZE - offset). Each later chunk is min(PAGE_SIZE, bytes left). The page index goes up by one after each chunk, and the offset becomes 0.
- R4: A chunk shorter than PAGE_SIZE is preceded by a 4-byte fill frame: 0x53, then the 24-bit value page << PAGE_SHIFT, sent most significant byte first.
- R5: Each chunk is programmed in one chip-select frame: 0x82, then the 24-bit value (page << PAGE_SHIFT) + offset sent most significant byte first, then the chunk bytes in input order.
- R6: After every fill, program or compare frame, the block sends status frames of two bytes (0xD7, then a dummy byte). The reply to the second byte is the status. The block repeats these frames until status bit 7 is 1, and it starts no other command before that.
- R7: With verify_en = 1 at start, each program is followed by a 4-byte compare frame: 0x60, then page << PAGE_SHIFT sent most significant byte first. With verify_en = 0, no compare frame is sent.
- R8: If status bit 6 is 1 in the ready status after a compare, the block sends no further frames. It pulses error, sets mismatch and puts that page index on err_page.
- R9: done and error are one-cycle pulses that never occur together. busy falls in the same cycle as one of them.
- R10: Every byte is accepted exactly once. spi_req is only asserted inside chip select, and spi_tx is held until spi_ack. A stream byte is taken (din_ready) only in the cycle its spi_ack arrives.
- R11: A new accepted start clears mismatch.
- R12: A start pulse while busy is ignored, and the run in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a write (sampled while idle) |
| start_addr | input | ADDR_W | Linear byte address of the first byte |
| byte_count | input | LEN_W | Number of bytes to write |
| verify_en | input | 1 | Run a compare after each program |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the run completes |
| error | output | 1 | One-cycle pulse when a compare fails |
| mismatch | output | 1 | Sticky compare-failure flag |
| err_page | output | ADDR_W | Page index of the failed compare |
| din_data | input | 8 | Stream byte |
| din_valid | input | 1 | Stream byte available |
| din_ready | output | 1 | Stream byte consumed this cycle |
| spi_sel | output | 1 | Chip select, active high |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Byte transfer complete |
| spi_rx | input | 8 | Byte shifted in during the acknowledged transfer |

## Verification
A zero-length done is due in the cycle after start. The bench samples it on the falling edge that follows that clock edge.

The error pulse comes a few cycles after the ready status of the failing compare. The done pulse comes a few cycles after the last ready status, and busy falls in that same cycle. The bench therefore waits for either pulse on falling edges, checks busy at that falling edge, and checks that the pulse has gone at the next one.

The frame contents are captured by a device model as each byte is acknowledged. When chip select drops, the model compares the frame against a list the bench builds from the address, the length and the verify setting.

// File: rtl/pwseq_pkg.sv
package pwseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCATE,
        ST_PLAN,
        ST_SEND,
        ST_DATA,
        ST_GAP,
        ST_DECIDE,
        ST_ADV
    } pw_state_e;

    typedef enum logic [1:0] {
        OP_FILL,
        OP_PROG,
        OP_CMPR
    } pw_op_e;

    localparam logic [7:0] CODE_FILL = 8'h53;
    localparam logic [7:0] CODE_PROG = 8'h82;
    localparam logic [7:0] CODE_CMPR = 8'h60;
    localparam logic [7:0] CODE_STAT = 8'hD7;
    localparam int unsigned FLASH_AW = 24;
endpackage

// File: rtl/pwseq_locate.sv
module pwseq_locate #(
    parameter int unsigned PAGE_SIZE = 264,
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned OFF_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] page,
    output logic [OFF_W-1:0]  offset,
    output logic              found
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PAGE_SIZE);

    typedef struct packed {
        logic              run;
        logic              fin;
        logic [ADDR_W-1:0] rem;
        logic [ADDR_W-1:0] pg;
    } loc_t;

    loc_t loc_d, loc_q;

    // one subtraction per cycle; page size need not be a power of two
    always_comb begin
        loc_d     = loc_q;
        loc_d.fin = 1'b0;
        if (go) begin
            loc_d.run = 1'b1;
            loc_d.rem = addr;
            loc_d.pg  = '0;
        end else if (loc_q.run) begin
            if (loc_q.rem >= STEP) begin
                loc_d.rem = loc_q.rem - STEP;
                loc_d.pg  = loc_q.pg + ADDR_W'(1);
            end else begin
                loc_d.run = 1'b0;
                loc_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loc_q <= '0;
        else        loc_q <= loc_d;
    end

    assign page   = loc_q.pg;
    assign offset = loc_q.rem[OFF_W-1:0];
    assign found  = loc_q.fin;
endmodule

// File: rtl/pwseq_chunk.sv
module pwseq_chunk #(
    parameter int unsigned PAGE_SIZE = 264,
    parameter int unsigned LEN_W     = 20,
    parameter int unsigned OFF_W     = 9
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] len,
    output logic             partial
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(PAGE_SIZE);

    logic [LEN_W-1:0] room;

    always_comb begin
        room    = FULL - LEN_W'(offset);
        len     = (remain < room) ? remain : room;
        partial = (len != FULL);
    end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
    import pwseq_pkg::*;
#(
    parameter int unsigned PAGE_SIZE  = 264,
    parameter int unsigned PAGE_SHIFT = 9,
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned LEN_W      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  byte_count,
    input  logic              verify_en,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              mismatch,
    output logic [ADDR_W-1:0] err_page,
    input  logic [7:0]        din_data,
    input  logic              din_valid,
    output logic              din_ready,
    output logic              spi_sel,
    output logic              spi_req,
    output logic [7:0]        spi_tx,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx
);
    localparam int unsigned OFF_W = PAGE_SHIFT;

    typedef struct packed {
        pw_state_e         st;
        pw_op_e            op;
        logic              poll;
        logic [1:0]        idx;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  remain;
        logic [LEN_W-1:0]  chunk;
        logic [ADDR_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic [7:0]        status;
        logic              vfy;
        logic              done;
        logic              err;
        logic              mism;
        logic [ADDR_W-1:0] epage;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                loc_go, loc_found;
    logic [ADDR_W-1:0]   loc_page;
    logic [OFF_W-1:0]    loc_off;
    logic [LEN_W-1:0]    ck_len;
    logic                ck_part;
    logic [FLASH_AW-1:0] faddr;
    logic [7:0]          opcode, frame_byte;
    logic                last_byte;

    assign loc_go = (ctl_q.st == ST_IDLE) && start && (byte_count != '0);

    pwseq_locate #(.PAGE_SIZE(PAGE_SIZE), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_locate (
        .clk(clk), .rst_n(rst_n), .go(loc_go), .addr(start_addr),
        .page(loc_page), .offset(loc_off), .found(loc_found)
    );

    pwseq_chunk #(.PAGE_SIZE(PAGE_SIZE), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_chunk (
        .offset(ctl_q.off), .remain(ctl_q.remain), .len(ck_len), .partial(ck_part)
    );

    // bytes of the current frame
    always_comb begin
        faddr = (FLASH_AW'(ctl_q.page) << PAGE_SHIFT)
              + ((ctl_q.op == OP_PROG) ? FLASH_AW'(ctl_q.off) : '0);
        case (ctl_q.op)
            OP_FILL: opcode = CODE_FILL;
            OP_PROG: opcode = CODE_PROG;
            default: opcode = CODE_CMPR;
        endcase
        case (ctl_q.idx)
            2'd0:    frame_byte = ctl_q.poll ? CODE_STAT : opcode;
            2'd1:    frame_byte = ctl_q.poll ? 8'h00 : faddr[23:16];
            2'd2:    frame_byte = faddr[15:8];
            default: frame_byte = faddr[7:0];
        endcase
        last_byte = ctl_q.poll ? (ctl_q.idx == 2'd1) : (ctl_q.idx == 2'd3);
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: if (start) begin
                ctl_d.mism   = 1'b0;
                ctl_d.vfy    = verify_en;
                ctl_d.remain = byte_count;
                if (byte_count == '0) ctl_d.done = 1'b1;
                else                  ctl_d.st   = ST_LOCATE;
            end
            ST_LOCATE: if (loc_found) begin
                ctl_d.page = loc_page;
                ctl_d.off  = loc_off;
                ctl_d.st   = ST_PLAN;
            end
            ST_PLAN: begin
                ctl_d.chunk = ck_len;
                ctl_d.op    = ck_part ? OP_FILL : OP_PROG;
                ctl_d.idx   = '0;
                ctl_d.poll  = 1'b0;
                ctl_d.st    = ST_SEND;
            end
            ST_SEND: if (spi_ack) begin
                ctl_d.idx = ctl_q.idx + 2'd1;
                if (last_byte) begin
                    ctl_d.idx = '0;
                    if (ctl_q.poll) begin
                        ctl_d.status = spi_rx;
                        ctl_d.st     = ST_DECIDE;
                    end else if (ctl_q.op == OP_PROG) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_DATA;
                    end else begin
                        ctl_d.st = ST_GAP;
                    end
                end
            end
            ST_DATA: if (spi_ack) begin
                ctl_d.cnt = ctl_q.cnt + LEN_W'(1);
                if (ctl_q.cnt == ctl_q.chunk - LEN_W'(1)) ctl_d.st = ST_GAP;
            end
            ST_GAP: begin
                ctl_d.poll = 1'b1;
                ctl_d.idx  = '0;
                ctl_d.st   = ST_SEND;
            end
            ST_DECIDE: begin
                if (!ctl_q.status[7]) begin
                    ctl_d.st = ST_SEND;
                end else begin
                    ctl_d.poll = 1'b0;
                    case (ctl_q.op)
                        OP_FILL: begin
                            ctl_d.op = OP_PROG;
                            ctl_d.st = ST_SEND;
                        end
                        OP_PROG: begin
                            if (ctl_q.vfy) begin
                                ctl_d.op = OP_CMPR;
                                ctl_d.st = ST_SEND;
                            end else begin
                                ctl_d.st = ST_ADV;
                            end
                        end
                        default: begin
                            if (ctl_q.status[6]) begin
                                ctl_d.err   = 1'b1;
                                ctl_d.mism  = 1'b1;
                                ctl_d.epage = ctl_q.page;
                                ctl_d.st    = ST_IDLE;
                            end else begin
                                ctl_d.st = ST_ADV;
                            end
                        end
                    endcase
                end
            end
            ST_ADV: begin
                ctl_d.remain = ctl_q.remain - ctl_q.chunk;
                ctl_d.page   = ctl_q.page + ADDR_W'(1);
                ctl_d.off    = '0;
                if (ctl_q.remain == ctl_q.chunk) begin
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end else begin
                    ctl_d.st = ST_PLAN;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign spi_sel   = (ctl_q.st == ST_SEND) || (ctl_q.st == ST_DATA);
    assign spi_req   = (ctl_q.st == ST_SEND) || ((ctl_q.st == ST_DATA) && din_valid);
    assign spi_tx    = (ctl_q.st == ST_DATA) ? din_data : frame_byte;
    assign din_ready = (ctl_q.st == ST_DATA) && spi_ack;
    assign busy      = (ctl_q.st != ST_IDLE);
    assign done      = ctl_q.done;
    assign error     = ctl_q.err;
    assign mismatch  = ctl_q.mism;
    assign err_page  = ctl_q.epage;
endmodule

// File: rtl/pwseq_checker.sv
module pwseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       mismatch,
    input logic       spi_sel,
    input logic       spi_req,
    input logic [7:0] spi_tx,
    input logic       spi_ack,
    input logic       din_ready
);
    a_r10_req_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> spi_sel);

    a_r10_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

    a_r10_take_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> (spi_ack && spi_sel));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r9_end_marker: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || error));

    a_r8_flag_with_error: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> mismatch);

    a_r11_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !mismatch);
endmodule

bind page_write_seq pwseq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .mismatch(mismatch), .spi_sel(spi_sel), .spi_req(spi_req),
    .spi_tx(spi_tx), .spi_ack(spi_ack), .din_ready(din_ready)
);

// File: tb/page_write_seq_bench.sv
module page_write_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PS = 20;
    localparam int SH = 5;
    localparam int AW = 12;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] byte_count = '0;
    logic          verify_en = 1'b0;
    logic          busy, done, error, mismatch, din_ready, spi_sel, spi_req;
    logic [AW-1:0] err_page;
    logic [7:0]    spi_tx;
    logic [7:0]    din_data = 8'h00;
    logic          din_valid = 1'b0;
    logic          spi_ack = 1'b0;
    logic [7:0]    spi_rx = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_write_seq #(.PAGE_SIZE(PS), .PAGE_SHIFT(SH), .ADDR_W(AW), .LEN_W(LW)) u_page_write_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .verify_en(verify_en), .busy(busy), .done(done),
        .error(error), .mismatch(mismatch), .err_page(err_page),
        .din_data(din_data), .din_valid(din_valid), .din_ready(din_ready),
        .spi_sel(spi_sel), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model state (written only by the model process, except the knobs)
    int         arm_req = 0;
    int         arm_seen = 0;
    logic [7:0] seed = 8'h00;
    int         fail_cmp = -1;
    int         nf, polls, exp_polls, viol, data_idx, data_bad, cmp_seen, busy_left, fb, sel_cycles;
    logic [7:0] fr_op [64];
    int         fr_addr [64];
    int         fr_len [64];
    logic [7:0] fbyte [4];
    logic       sel_prev, pend, mism_bit;

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37) + seed;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            spi_ack  = 1'b0;
            sel_prev = 1'b0;
        end else begin
            spi_ack = 1'b0;
            if (arm_seen != arm_req) begin
                arm_seen = arm_req;
                nf = 0; polls = 0; exp_polls = 0; viol = 0; data_idx = 0; data_bad = 0;
                cmp_seen = 0; busy_left = 0; fb = 0; pend = 1'b0; mism_bit = 1'b0;
                sel_cycles = 0;
                din_data = pat(0);
                din_valid = 1'b0;
            end
            if (spi_sel) sel_cycles++;
            if (spi_sel && !sel_prev) fb = 0;
            if (!spi_sel && sel_prev && fbyte[0] != 8'hD7) begin
                if (nf < 64) begin
                    fr_op[nf]   = fbyte[0];
                    fr_addr[nf] = {8'h00, fbyte[1], fbyte[2], fbyte[3]};
                    fr_len[nf]  = fb;
                end
                nf++;
                busy_left = $urandom % 3;
                exp_polls += busy_left + 1;
                mism_bit = 1'b0;
                if (fbyte[0] == 8'h60) begin
                    mism_bit = (cmp_seen == fail_cmp);
                    cmp_seen++;
                end
            end
            sel_prev = spi_sel;
            if (pend) begin
                data_idx++;
                din_data  = pat(data_idx);
                din_valid = ($urandom % 4) != 0;
                pend = 1'b0;
            end else if (!din_valid && ($urandom % 2) == 1) begin
                din_valid = 1'b1;
            end else if (spi_req && ($urandom % 4) != 0) begin
                spi_ack = 1'b1;
                if (fb < 4) fbyte[fb] = spi_tx;
                if (fb == 0 && spi_tx != 8'hD7 && busy_left != 0) viol++;
                if (fb == 1 && fbyte[0] == 8'hD7) begin
                    spi_rx = {(busy_left == 0), mism_bit, 6'b0};
                    if (busy_left > 0) busy_left--;
                    polls++;
                end
                if (fb >= 4 && fbyte[0] == 8'h82) begin
                    if (spi_tx != pat(data_idx)) data_bad++;
                    pend = 1'b1;
                end
                fb++;
            end
        end
    end

    bit abort = 1'b0;

    task automatic arm();
        @(negedge clk);
        seed = 8'($urandom);
        arm_req++;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input int addr, input int len, input bit vfy, input int failc);
        logic [7:0] e_op [64];
        int e_addr [64];
        int e_len [64];
        int ek, pg, off, rem, ch, ci, ebytes, epage, cyc, nbad4, nbad5, nbad7;
        bit eerr, fin, pulsed, got_done, got_err;
        if (abort) return;
        fail_cmp = failc;
        arm();
        start = 1'b1; start_addr = AW'(addr); byte_count = LW'(len); verify_en = vfy;
        @(negedge clk);
        start = 1'b0;
        chk(mismatch == 1'b0, "R11 mismatch cleared by start", int'(mismatch), 0);
        cyc = 0; fin = 1'b0; pulsed = 1'b0; got_done = 1'b0; got_err = 1'b0;
        while (!fin) begin
            if (done || error) begin
                fin = 1'b1; got_done = done; got_err = error;
                chk(busy == 1'b0, "R9 busy falls with end pulse", int'(busy), 0);
            end else begin
                if (cyc == 30 && busy) begin
                    start = 1'b1; start_addr = AW'(7); byte_count = LW'(3); verify_en = ~vfy;
                    pulsed = 1'b1;
                end else begin
                    start = 1'b0;
                end
                if (cyc > 20000) begin
                    chk(1'b0, "watchdog run did not end", cyc, 0);
                    abort = 1'b1; fin = 1'b1;
                end
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        if (abort) return;
        @(negedge clk);
        chk(done == 1'b0 && error == 1'b0, "R9 end pulse lasts one cycle", int'(done | error), 0);
        // expected frames
        pg = addr / PS; off = addr % PS; rem = len; ek = 0; ci = 0; ebytes = 0; eerr = 1'b0; epage = 0;
        while (rem > 0) begin
            ch = (PS - off < rem) ? PS - off : rem;
            if (ch != PS) begin e_op[ek] = 8'h53; e_addr[ek] = pg << SH; e_len[ek] = 4; ek++; end
            e_op[ek] = 8'h82; e_addr[ek] = (pg << SH) + off; e_len[ek] = 4 + ch; ek++;
            ebytes += ch;
            if (vfy) begin
                e_op[ek] = 8'h60; e_addr[ek] = pg << SH; e_len[ek] = 4; ek++;
                if (ci == failc) begin eerr = 1'b1; epage = pg; break; end
            end
            ci++; rem -= ch; pg++; off = 0;
        end
        chk(nf == ek, "R3 number of command frames", nf, ek);
        if (pulsed) chk(nf == ek, "R12 start while busy ignored", nf, ek);
        nbad4 = 0; nbad5 = 0; nbad7 = 0;
        for (int i = 0; i < ek && i < nf; i++) begin
            if (fr_op[i] != e_op[i] || fr_addr[i] != e_addr[i] || fr_len[i] != e_len[i]) begin
                if (e_op[i] == 8'h53) nbad4++;
                else if (e_op[i] == 8'h82) nbad5++;
                else nbad7++;
            end
        end
        chk(nbad4 == 0, "R4 fill frames", nbad4, 0);
        chk(nbad5 == 0, "R5 program frames", nbad5, 0);
        chk(nbad7 == 0, "R7 compare frames", nbad7, 0);
        chk(data_bad == 0, "R5 data byte order", data_bad, 0);
        chk(data_idx == ebytes, "R10 each stream byte taken once", data_idx, ebytes);
        chk(viol == 0, "R6 command while device busy", viol, 0);
        chk(polls == exp_polls, "R6 status polls until ready", polls, exp_polls);
        chk(got_err == eerr, "R8 error pulse", int'(got_err), int'(eerr));
        chk(got_done == !eerr, "R9 done pulse", int'(got_done), int'(!eerr));
        chk(mismatch == eerr, "R8 mismatch flag", int'(mismatch), int'(eerr));
        if (eerr) chk(int'(err_page) == epage, "R8 failing page", int'(err_page), epage);
    endtask

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !mismatch && !spi_sel && !spi_req && !din_ready,
            "R1 outputs during reset", int'(busy | done | error | spi_sel | spi_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !error && !mismatch && !spi_sel && !spi_req && !din_ready,
            "R1 outputs after reset", int'(busy | done | error | spi_sel | spi_req), 0);

        // R2: zero length
        arm();
        start = 1'b1; start_addr = AW'(33); byte_count = '0; verify_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R2 zero length done next cycle", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R2 zero length single pulse", int'(done), 0);
        chk(sel_cycles == 0 && nf == 0, "R2 zero length no chip select", sel_cycles, 0);

        run_case(40, 20, 1'b0, -1);   // aligned full page
        run_case(45, 30, 1'b0, -1);   // crosses a page end, both chunks partial
        run_case(0, 50, 1'b1, -1);    // verify, no mismatch
        run_case(3, 50, 1'b1, 1);     // mismatch at second compare
        run_case(19, 1, 1'b1, -1);    // last byte of a page
        run_case(4095, 1, 1'b0, -1);  // highest address
        for (int k = 0; k < 20; k++) begin
            int a, l, f;
            bit v;
            a = $urandom % 4000;
            l = 1 + ($urandom % 70);
            v = $urandom % 2;
            f = (v && ($urandom % 4) == 0) ? int'($urandom % 3) : -1;
            run_case(a, l, v, f);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule